// File: doc/BRIEF.md
# Serial Bit Clock Selector and Gate

This block produces the bit-clock enables that drive a synchronous serial channel's shifter, and it decides whether a bit clock is driven out to a pin. All of its logic runs in one fast system clock domain. It does not switch clocks. It follows the level of a selected bit-clock source and turns each edge of that level into a one-cycle enable pulse. The source is one of three: a clock divided down from the system clock, the clock level of the companion channel (which is already in the system domain), or an external clock pin. The pin passes through a synchronizer first.

Before edges are detected, the selected level can be gated by the frame-sync line. While the gate is closed, the level is held low. An inversion input chooses which edge is the sampling edge and which is the shifting edge. The inversion has no effect on the clock driven out.

The clock output has three modes. In the first, the pin stays an input. In the second, the gated clock is driven all the time. In the third, the clock is driven only while a word is in transfer. In that mode the transfer window opens and closes only while the clock is low, so no pulse on the pin is ever cut short or started part way through.

Top module: `bitclk_selgate`

## Requirements
- R1: `src_sel` picks the bit-clock source: 0 is the internal divided clock, 1 is `peer_clk`, 2 is the synchronized `ext_clk`, and 3 is no clock. With code 3, the selected level stays low and no edge enable is produced.
- R2: With source 0 and a nonzero `div_val` of d, the divided clock toggles every d system cycles. `rise_en` therefore repeats every 2·d cycles and `clk_out` is high for d of them. When `div_val` is 0, the divided clock stops low.
- R3: `ext_clk` passes through SYNC_STAGES flops before use. With SYNC_STAGES = 2, a change driven between edges shows up as an edge enable after the third rising system edge, and not earlier.
- R4: `rise_en` (or `fall_en`) is high for exactly one cycle, in the cycle after the registered gated level changes from low to high (or from high to low). The two are never high together.
- R5: `gate_mode` 0 and 3 never gate. Mode 1 passes the clock only while `fsync` is low, and mode 2 only while `fsync` is high. A closed gate holds the gated level low, which produces a falling edge if the level was high.
- R6: With `inv` = 0, `sample_en` follows `fall_en` and `shift_en` follows `rise_en`. With `inv` = 1 they swap. `inv` never changes `clk_out`.
- R7: `out_mode` 0 and 3 hold `clk_oe` and `clk_out` low. Mode 1 sets `clk_oe` and drives the gated level on `clk_out`, registered with the same one-cycle delay as the edge enables.
- R8: In `out_mode` 2, `clk_oe` is high and `clk_out` carries the gated clock only while the transfer window is open. The window takes the value of `xfer_active` only in cycles where the gated level is low. A high clock phase is therefore never cut short, and a word that arrives mid-phase waits for the next low phase.
- R9: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Half-period of the divided clock in system cycles; 0 stops it |
| src_sel | input | 2 | Bit-clock source code |
| peer_clk | input | 1 | Companion channel clock level, system domain |
| ext_clk | input | 1 | External clock pin, asynchronous |
| gate_mode | input | 2 | Frame-sync gating code |
| fsync | input | 1 | Frame-sync level, system domain |
| inv | input | 1 | Sampling-edge select |
| out_mode | input | 2 | Clock output mode code |
| xfer_active | input | 1 | A word is being transferred |
| rise_en | output | 1 | Rising bit-clock edge enable |
| fall_en | output | 1 | Falling bit-clock edge enable |
| sample_en | output | 1 | Edge enable on which data and frame sync are sampled |
| shift_en | output | 1 | Edge enable on which data is shifted out |
| clk_out | output | 1 | Bit clock value for the pad |
| clk_oe | output | 1 | Pad output enable for the bit clock |

## Verification
The bench builds the block with DIV_W = 4 and SYNC_STAGES = 2. The narrow divider puts the largest half-period (15) within reach of a short run, so the wrap of the divider counter at its full range is tested along with the smallest nonzero value and the stopped value 0. With two synchronizer stages, the external-pin latency is a fixed three cycles, so the bench can check it edge for edge. The mode and gating tables use the companion source, whose level reaches the enables one cycle later. The bench can therefore predict each cycle's rise, fall, sample, shift, clock-out and enable values directly from the requirement text.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   typedef enum logic [1:0] {
      SRC_DIV  = 2'd0,
      SRC_PEER = 2'd1,
      SRC_PIN  = 2'd2,
      SRC_OFF  = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      GATE_NONE    = 2'd0,
      GATE_FS_LOW  = 2'd1,
      GATE_FS_HIGH = 2'd2,
      GATE_SPARE   = 2'd3
   } gate_e;

   typedef enum logic [1:0] {
      OUT_NONE = 2'd0,
      OUT_CONT = 2'd1,
      OUT_XFER = 2'd2,
      OUT_SPARE = 2'd3
   } omode_e;

endpackage

// File: rtl/bcg_divider.sv
module bcg_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   output logic             div_clk
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt_q;
   logic             lvl_q;
   logic             wrap;

   // Counter has reached the last cycle of a half-period.
   assign wrap = (cnt_q >= (div_val - ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (div_val == '0) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         lvl_q <= ~lvl_q;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign div_clk = lvl_q;
endmodule

// File: rtl/bcg_sync.sv
module bcg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bcg_gate_edge.sv
module bcg_gate_edge
   import bcg_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sel_lvl,
   input  gate_e gate_mode,
   input  logic  fsync,
   input  logic  inv,
   output logic  gated,
   output logic  rise_en,
   output logic  fall_en,
   output logic  sample_en,
   output logic  shift_en
);
   logic gate_open;
   logic lvl_q;
   logic lvl_qq;

   always_comb begin
      unique case (gate_mode)
         GATE_FS_LOW:  gate_open = ~fsync;
         GATE_FS_HIGH: gate_open = fsync;
         default:      gate_open = 1'b1;
      endcase
   end

   // Closed gate parks the clock at its low level.
   assign gated = sel_lvl & gate_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         lvl_qq <= 1'b0;
      end else begin
         lvl_q  <= gated;
         lvl_qq <= lvl_q;
      end
   end

   assign rise_en   = lvl_q & ~lvl_qq;
   assign fall_en   = ~lvl_q & lvl_qq;
   assign sample_en = inv ? rise_en : fall_en;
   assign shift_en  = inv ? fall_en : rise_en;
endmodule

// File: rtl/bcg_outdrv.sv
module bcg_outdrv
   import bcg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  omode_e out_mode,
   input  logic   gated,
   input  logic   xfer_active,
   output logic   clk_out,
   output logic   clk_oe
);
   logic win_q;
   logic win_nxt;
   logic co_q;
   logic oe_q;

   // Window may only move while the clock sits low.
   assign win_nxt = gated ? win_q : xfer_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= 1'b0;
         co_q  <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         win_q <= win_nxt;
         unique case (out_mode)
            OUT_CONT: begin
               co_q <= gated;
               oe_q <= 1'b1;
            end
            OUT_XFER: begin
               co_q <= gated & win_nxt;
               oe_q <= 1'b1;
            end
            default: begin
               co_q <= 1'b0;
               oe_q <= 1'b0;
            end
         endcase
      end
   end

   assign clk_out = co_q;
   assign clk_oe  = oe_q;
endmodule

// File: rtl/bitclk_selgate.sv
module bitclk_selgate
   import bcg_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic [1:0]       src_sel,
   input  logic             peer_clk,
   input  logic             ext_clk,
   input  logic [1:0]       gate_mode,
   input  logic             fsync,
   input  logic             inv,
   input  logic [1:0]       out_mode,
   input  logic             xfer_active,
   output logic             rise_en,
   output logic             fall_en,
   output logic             sample_en,
   output logic             shift_en,
   output logic             clk_out,
   output logic             clk_oe
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("bitclk_selgate: DIV_W must lie in 1..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bitclk_selgate: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic  div_lvl;
   logic  pin_lvl;
   logic  sel_lvl;
   logic  gated;
   src_e  src;

   assign src = src_e'(src_sel);

   bcg_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_val (div_val),
      .div_clk (div_lvl)
   );

   bcg_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_clk),
      .q     (pin_lvl)
   );

   always_comb begin
      unique case (src)
         SRC_DIV:  sel_lvl = div_lvl;
         SRC_PEER: sel_lvl = peer_clk;
         SRC_PIN:  sel_lvl = pin_lvl;
         default:  sel_lvl = 1'b0;
      endcase
   end

   bcg_gate_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_lvl   (sel_lvl),
      .gate_mode (gate_e'(gate_mode)),
      .fsync     (fsync),
      .inv       (inv),
      .gated     (gated),
      .rise_en   (rise_en),
      .fall_en   (fall_en),
      .sample_en (sample_en),
      .shift_en  (shift_en)
   );

   bcg_outdrv u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .out_mode    (omode_e'(out_mode)),
      .gated       (gated),
      .xfer_active (xfer_active),
      .clk_out     (clk_out),
      .clk_oe      (clk_oe)
   );
endmodule

// File: rtl/bitclk_selgate_chk.sv
module bitclk_selgate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] src_sel,
   input logic [1:0] gate_mode,
   input logic       fsync,
   input logic [1:0] out_mode,
   input logic       rise_en,
   input logic       fall_en,
   input logic       sample_en,
   input logic       shift_en,
   input logic       clk_out,
   input logic       clk_oe
);
   assert_src_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(src_sel) == 2'd3) |-> !rise_en);

   assert_edge_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_en && fall_en));

   assert_gate_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(gate_mode) == 2'd1 && $past(fsync)) |-> !rise_en);

   assert_gate_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(gate_mode) == 2'd2 && !$past(fsync)) |-> !rise_en);

   assert_role_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_en && shift_en));

   assert_role_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en || shift_en) == (rise_en || fall_en));

   assert_pin_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_oe |-> !clk_out);

   assert_mode_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(out_mode) == 2'd0) |-> (!clk_oe && !clk_out));
endmodule

bind bitclk_selgate bitclk_selgate_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_sel   (src_sel),
   .gate_mode (gate_mode),
   .fsync     (fsync),
   .out_mode  (out_mode),
   .rise_en   (rise_en),
   .fall_en   (fall_en),
   .sample_en (sample_en),
   .shift_en  (shift_en),
   .clk_out   (clk_out),
   .clk_oe    (clk_oe)
);

// File: tb/bitclk_selgate_tb.sv
module bitclk_selgate_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DIV_W      = 4;
   localparam int NROWS      = 22;

   // {peer, fsync, gate[1:0], inv, omode[1:0], xfer | rise, fall, sample, shift, clk_out, oe}
   localparam logic [13:0] VEC [NROWS] = '{
      14'b1_0_00_0_01_0_100111,  // R4 R6 rise, inv 0
      14'b0_0_00_0_01_0_011001,  // R4 R6 fall
      14'b1_0_00_1_01_0_101011,  // R6 inv 1, clk_out unchanged
      14'b0_0_00_1_01_0_010101,
      14'b1_1_01_0_01_0_000001,  // R5 gate low closed
      14'b0_1_01_0_01_0_000001,
      14'b1_0_01_0_01_0_100111,  // R5 gate low open
      14'b1_1_01_0_01_0_011001,  // R5 gate forces low
      14'b1_1_10_0_01_0_100111,  // R5 gate high open
      14'b1_0_10_0_01_0_011001,
      14'b1_0_00_0_00_0_100100,  // R7 mode none
      14'b0_0_00_0_00_0_011000,
      14'b1_0_00_0_10_1_100101,  // R8 word mid-phase waits
      14'b0_0_00_0_10_1_011001,
      14'b1_0_00_0_10_1_100111,  // R8 clock inside window
      14'b1_0_00_0_10_0_000011,  // R8 pulse not truncated
      14'b0_0_00_0_10_0_011001,
      14'b1_0_00_0_10_0_100101,  // R8 window closed
      14'b0_0_00_0_10_0_011001,
      14'b1_0_00_0_11_1_100100,  // R7 spare mode
      14'b0_1_11_0_01_0_011001,  // R5 spare gate
      14'b1_1_11_0_01_0_100111
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] div_val = '0;
   logic [1:0]       src_sel = 2'd1;
   logic             peer_clk = 1'b0;
   logic             ext_clk = 1'b0;
   logic [1:0]       gate_mode = 2'd0;
   logic             fsync = 1'b0;
   logic             inv = 1'b0;
   logic [1:0]       out_mode = 2'd1;
   logic             xfer_active = 1'b0;
   logic             rise_en, fall_en, sample_en, shift_en, clk_out, clk_oe;

   int n_chk  = 0;
   int n_fail = 0;

   bitclk_selgate #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_dut (
      .clk (clk), .rst_n (rst_n), .div_val (div_val), .src_sel (src_sel),
      .peer_clk (peer_clk), .ext_clk (ext_clk), .gate_mode (gate_mode),
      .fsync (fsync), .inv (inv), .out_mode (out_mode),
      .xfer_active (xfer_active), .rise_en (rise_en), .fall_en (fall_en),
      .sample_en (sample_en), .shift_en (shift_en), .clk_out (clk_out),
      .clk_oe (clk_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Returns cycles between two rise pulses and high cycles of clk_out in between.
   task automatic measure(output int per, output int hi);
      int guard = 0;
      per = 0;
      hi  = 0;
      while (!rise_en && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      do begin
         if (clk_out) hi++;
         @(negedge clk);
         per++;
      end while (!rise_en && per < 200);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int per, hi, cnt;
      peer_clk = 1'b1;
      repeat (3) @(negedge clk);
      // R9: outputs held low in reset despite active inputs
      chk("R9 clk_oe in reset", int'(clk_oe), 0);
      chk("R9 clk_out in reset", int'(clk_out), 0);
      chk("R9 rise_en in reset", int'(rise_en), 0);
      peer_clk = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // Table walk on the companion source (R4 R5 R6 R7 R8)
      for (int i = 0; i < NROWS; i++) begin
         logic [13:0] v;
         v = VEC[i];
         peer_clk    = v[13];
         fsync       = v[12];
         gate_mode   = v[11:10];
         inv         = v[9];
         out_mode    = v[8:7];
         xfer_active = v[6];
         @(negedge clk);
         chk($sformatf("R4/R5/R6/R7/R8 row %0d", i),
             int'({rise_en, fall_en, sample_en, shift_en, clk_out, clk_oe}),
             int'(v[5:0]));
      end

      // R2 divider periods
      gate_mode = 2'd0; fsync = 1'b0; inv = 1'b0; out_mode = 2'd1;
      xfer_active = 1'b0; peer_clk = 1'b0;
      src_sel = 2'd0;
      div_val = 4'd3;
      repeat (2) @(negedge clk);
      measure(per, hi);
      chk("R2 period div 3", per, 6);
      chk("R2 high div 3", hi, 3);
      div_val = 4'd15;
      measure(per, hi);
      measure(per, hi);
      chk("R2 period div 15", per, 30);
      chk("R2 high div 15", hi, 15);
      div_val = 4'd1;
      measure(per, hi);
      measure(per, hi);
      chk("R2 period div 1", per, 2);
      chk("R2 high div 1", hi, 1);

      // R2 stop, R1 companion ignored under source 0
      div_val = 4'd0;
      repeat (4) @(negedge clk);
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         peer_clk = ~peer_clk;
         @(negedge clk);
         if (rise_en || clk_out) cnt++;
      end
      chk("R2 R1 stopped divider", cnt, 0);

      // R1 source 3 gives no clock
      src_sel = 2'd3;
      cnt = 0;
      for (int k = 0; k < 20; k++) begin
         peer_clk = ~peer_clk;
         ext_clk  = ~ext_clk;
         @(negedge clk);
         if (rise_en || fall_en) cnt++;
      end
      chk("R1 source off", cnt, 0);

      // R3 synchronized pin latency
      ext_clk = 1'b0;
      src_sel = 2'd2;
      repeat (5) @(negedge clk);
      ext_clk = 1'b1;
      @(negedge clk);
      chk("R3 rise after 1 edge", int'(rise_en), 0);
      @(negedge clk);
      chk("R3 rise after 2 edges", int'(rise_en), 0);
      @(negedge clk);
      chk("R3 rise after 3 edges", int'(rise_en), 1);
      ext_clk = 1'b0;
      repeat (2) @(negedge clk);
      chk("R3 fall after 2 edges", int'(fall_en), 0);
      @(negedge clk);
      chk("R3 fall after 3 edges", int'(fall_en), 1);

      finish_run();
   end
endmodule